// File: doc/BRIEF.md
# Audio Stream Control Register

This block is the control and status register of one audio DMA stream. Software reaches it through a small register port with two addresses. One address holds a 32-bit control word: the stream tag, three interrupt enables, the run bit and the reset bit. The other address holds three sticky event flags, which software clears by writing 1 to them.

The run and reset bits are not plain storage. Each one drives a request towards the stream's DMA engine or FIFO. Its read-back value changes only when that hardware reports that the request has taken effect. Software therefore polls the read-back value to learn the real state of the stream. While the stream sits in reset, the descriptor fields are held cleared and software writes to them are discarded.

Completion, FIFO error and descriptor error events set their flags whether or not the matching enable is on. A single interrupt line combines each flag with its enable. The DMA data path, the FIFO storage and the link framing are outside this block; they appear only as handshake levels and event pulses.

Top module: `strm_ctl_reg`

## Requirements
- R1: Control bits 23:20 hold a read/write stream tag (value 0 is reserved, values 1 to 15 select a stream); bits 31:24 read 0.
- R2: Control bit 18 always reads 1; bits 19, 17:16 and 15:5 always read 0; writes to them have no effect.
- R3: Control bits 2, 3 and 4 are read/write enables for the completion, FIFO error and descriptor error interrupts.
- R4: At the status address (reg_sel=1), bit 2 is set by ev_ioc, bit 3 by ev_fifo_err and bit 4 by ev_desc_err, whatever the enables hold; all other status bits read 0.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged; an event in the same cycle as its clear leaves the bit set.
- R6: irq is high exactly when some status bit and its enable are both 1.
- R7: Writing run=1 (bit 1) makes the bit read 1 after that clock; dma_run is high while run is requested and ssync_hold is low.
- R8: Writing run=0 drops dma_run after that clock, but bit 1 keeps reading 1 until dma_idle is seen high, after which it reads 0.
- R9: With OUT_STREAM=1, a write that takes run from 0 to 1 produces a cad_rst pulse exactly one cycle long.
- R10: Writing reset=1 (bit 0) raises strm_rst; bit 0 reads 0 until rst_done is seen, then reads 1, and tag, enables and status read 0.
- R11: Writing reset=0 while bit 0 reads 1 drops strm_rst after that clock; bit 0 keeps reading 1 until strm_ready is seen, then reads 0.
- R12: A reset request is accepted only while bit 1 reads 0 and the same write leaves run at 0; otherwise it has no effect.
- R13: While bit 0 reads 1, writes to the tag, the enables and run have no effect, and events do not set status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the status word |
| wr_en | input | 1 | Write strobe for the selected word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected word |
| dma_idle | input | 1 | DMA engine reports that it has stopped |
| ssync_hold | input | 1 | Stream synchronisation hold; keeps the engine idle |
| rst_done | input | 1 | Stream hardware reports that it has entered reset |
| strm_ready | input | 1 | Stream hardware reports that it is ready after reset |
| ev_ioc | input | 1 | Buffer with its completion flag has finished |
| ev_fifo_err | input | 1 | FIFO overrun or underrun; the samples are dropped |
| ev_desc_err | input | 1 | Descriptor error |
| dma_run | output | 1 | Enable for the DMA engine |
| cad_rst | output | 1 | One-cycle reset pulse to the output cadence generator |
| strm_rst | output | 1 | Reset request to the stream FIFO and engine |
| irq | output | 1 | Stream interrupt |

## Verification
Two things can land on the same status bit in one clock: a hardware event that sets it and a software write that clears it. The bench pulses ev_fifo_err in the same clock as a write of 1 to status bit 3. It then expects the bit to read 1 and irq to stay high. A second collision is a reset request written while run still reads 1 because the engine has not stopped. That request must leave strm_rst low and bit 0 at 0.

// File: rtl/strm_ctl_pkg.sv
package strm_ctl_pkg;

    localparam int CTL_W     = 32;
    localparam int STS_N     = 3;
    localparam int BIT_SRST  = 0;
    localparam int BIT_RUN   = 1;
    localparam int BIT_EN_LO = 2;
    localparam int BIT_PRIO  = 18;
    localparam int BIT_TAG   = 20;

    typedef enum logic [1:0] {
        RS_NORM  = 2'd0,
        RS_ENTER = 2'd1,
        RS_IN    = 2'd2,
        RS_EXIT  = 2'd3
    } rst_state_e;

endpackage

// File: rtl/strm_ctl_hs.sv
module strm_ctl_hs
    import strm_ctl_pkg::*;
#(
    parameter bit OUT_STREAM = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctl,
    input  logic wr_run,
    input  logic wr_srst,
    input  logic dma_idle,
    input  logic ssync_hold,
    input  logic rst_done,
    input  logic strm_ready,
    output logic run_rd,
    output logic srst_rd,
    output logic enter_done,
    output logic dma_run,
    output logic cad_rst,
    output logic strm_rst
);

    typedef struct packed {
        rst_state_e st;
        logic       run_req;
        logic       run_rd;
        logic       cad;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d       = hs_q;
        hs_d.cad   = 1'b0;
        enter_done = 1'b0;
        case (hs_q.st)
            RS_NORM: begin
                if (wr_ctl) begin
                    hs_d.run_req = wr_run;
                    if (wr_run) begin
                        hs_d.run_rd = 1'b1;
                        hs_d.cad    = OUT_STREAM && !hs_q.run_req;
                    end
                    if (wr_srst && !wr_run && !hs_q.run_rd) begin
                        hs_d.st = RS_ENTER;
                    end
                end
            end
            RS_ENTER: begin
                if (rst_done) begin
                    hs_d.st    = RS_IN;
                    enter_done = 1'b1;
                end
            end
            RS_IN: begin
                if (wr_ctl && !wr_srst) begin
                    hs_d.st = RS_EXIT;
                end
            end
            RS_EXIT: begin
                if (strm_ready) begin
                    hs_d.st = RS_NORM;
                end
            end
            default: hs_d.st = RS_NORM;
        endcase
        if (!hs_d.run_req && hs_q.run_rd && !hs_q.run_req && dma_idle) begin
            hs_d.run_rd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '{st: RS_NORM, run_req: 1'b0, run_rd: 1'b0, cad: 1'b0};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign run_rd   = hs_q.run_rd;
    assign srst_rd  = (hs_q.st == RS_IN) || (hs_q.st == RS_EXIT);
    assign dma_run  = hs_q.run_req && !ssync_hold;
    assign cad_rst  = hs_q.cad;
    assign strm_rst = (hs_q.st == RS_ENTER) || (hs_q.st == RS_IN);

    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_q.run_req && hs_q.run_rd && !dma_idle) |=> run_rd);
    assert_dma_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_run |-> run_rd);
    assert_cad_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cad_rst |=> !cad_rst);
    assert_rst_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wr_srst && run_rd && hs_q.st == RS_NORM) |=> (hs_q.st == RS_NORM));
    assert_srst_norun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_rd |-> !run_rd);

endmodule

// File: rtl/strm_ctl_sts.sv
module strm_ctl_sts #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         w1c_en,
    input  logic [N-1:0] w1c_mask,
    input  logic         clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] sts,
    output logic         irq
);

    logic [N-1:0] sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        if (w1c_en) begin
            sts_d = sts_d & ~w1c_mask;
        end
        sts_d = sts_d | ev;
        if (clr) begin
            sts_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign sts = sts_q;
    assign irq = |(sts_q & en);

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (ev[i] && !clr) |=> sts[i]);
        end
    endgenerate

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($countones(sts) > 0));
    assert_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sts == '0));

endmodule

// File: rtl/strm_ctl_reg.sv
module strm_ctl_reg
    import strm_ctl_pkg::*;
#(
    parameter int TAG_W      = 4,
    parameter bit OUT_STREAM = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        dma_idle,
    input  logic        ssync_hold,
    input  logic        rst_done,
    input  logic        strm_ready,
    input  logic        ev_ioc,
    input  logic        ev_fifo_err,
    input  logic        ev_desc_err,
    output logic        dma_run,
    output logic        cad_rst,
    output logic        strm_rst,
    output logic        irq
);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [STS_N-1:0] en;
    } fld_t;

    fld_t fld_d, fld_q;

    logic             wr_ctl, wr_sts;
    logic             run_rd, srst_rd, enter_done;
    logic [STS_N-1:0] sts;
    logic [STS_N-1:0] ev_vec;

    assign wr_ctl = wr_en && !reg_sel;
    assign wr_sts = wr_en && reg_sel;
    assign ev_vec = {ev_desc_err, ev_fifo_err, ev_ioc};

    strm_ctl_hs #(.OUT_STREAM(OUT_STREAM)) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctl     (wr_ctl),
        .wr_run     (wr_data[BIT_RUN]),
        .wr_srst    (wr_data[BIT_SRST]),
        .dma_idle   (dma_idle),
        .ssync_hold (ssync_hold),
        .rst_done   (rst_done),
        .strm_ready (strm_ready),
        .run_rd     (run_rd),
        .srst_rd    (srst_rd),
        .enter_done (enter_done),
        .dma_run    (dma_run),
        .cad_rst    (cad_rst),
        .strm_rst   (strm_rst)
    );

    strm_ctl_sts #(.N(STS_N)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev_vec),
        .w1c_en   (wr_sts),
        .w1c_mask (wr_data[BIT_EN_LO +: STS_N]),
        .clr      (enter_done || srst_rd),
        .en       (fld_q.en),
        .sts      (sts),
        .irq      (irq)
    );

    always_comb begin
        fld_d = fld_q;
        if (wr_ctl && !srst_rd) begin
            fld_d.tag = wr_data[BIT_TAG +: TAG_W];
            fld_d.en  = wr_data[BIT_EN_LO +: STS_N];
        end
        if (enter_done || srst_rd) begin
            fld_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_sel) begin
            rd_data[BIT_EN_LO +: STS_N] = sts;
        end else begin
            rd_data[BIT_TAG +: TAG_W]    = fld_q.tag;
            rd_data[BIT_PRIO]            = 1'b1;
            rd_data[BIT_EN_LO +: STS_N]  = fld_q.en;
            rd_data[BIT_RUN]             = run_rd;
            rd_data[BIT_SRST]            = srst_rd;
        end
    end

    assert_locked_R13: assert property (@(posedge clk) disable iff (!rst_n)
        srst_rd |=> (fld_q == '0));
    assert_enter_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        enter_done |=> (srst_rd && fld_q == '0 && sts == '0));
    assert_exit_rstdrop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_rd && !strm_rst) |-> !dma_run);

endmodule

// File: tb/strm_ctl_reg_bench.sv
module strm_ctl_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        dma_idle = 1'b0, ssync_hold = 1'b0, rst_done = 1'b0, strm_ready = 1'b0;
    logic        ev_ioc = 1'b0, ev_fifo_err = 1'b0, ev_desc_err = 1'b0;
    logic        dma_run, cad_rst, strm_rst, irq;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    strm_ctl_reg #(.TAG_W(4), .OUT_STREAM(1'b1)) u_strm_ctl_reg (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .dma_idle(dma_idle),
        .ssync_hold(ssync_hold), .rst_done(rst_done), .strm_ready(strm_ready),
        .ev_ioc(ev_ioc), .ev_fifo_err(ev_fifo_err), .ev_desc_err(ev_desc_err),
        .dma_run(dma_run), .cad_rst(cad_rst), .strm_rst(strm_rst), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write one word; returns at the negedge after the capturing posedge
    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_ev(input logic [2:0] v);
        @(negedge clk);
        {ev_desc_err, ev_fifo_err, ev_ioc} = v;
        @(negedge clk);
        {ev_desc_err, ev_fifo_err, ev_ioc} = 3'b000;
    endtask

    task automatic t_reset_state;
        logic [31:0] d;
        rd(1'b0, d); chk("R2 reset ctl", d, 32'h0004_0000);
        rd(1'b1, d); chk("R4 reset sts", d, 32'h0);
        chk("R6 reset irq", {31'b0, irq}, 32'h0);
        chk("R10 reset strm_rst", {31'b0, strm_rst}, 32'h0);
    endtask

    task automatic t_fields;
        logic [31:0] d;
        wr(1'b0, 32'hFFFF_FFE0);
        rd(1'b0, d); chk("R1 R2 tag and fixed bits", d, 32'h00F4_0000);
        wr(1'b0, 32'h0050_0014);
        rd(1'b0, d); chk("R1 R3 tag 5 enables", d, 32'h0054_0014);
        wr(1'b0, 32'h0000_0008);
        rd(1'b0, d); chk("R3 fifo enable only", d, 32'h0004_0008);
    endtask

    task automatic t_status_irq;
        logic [31:0] d;
        wr(1'b0, 32'h0);
        pulse_ev(3'b010);
        rd(1'b1, d); chk("R4 fifo err sets bit3 without enable", d, 32'h8);
        chk("R6 irq off when disabled", {31'b0, irq}, 32'h0);
        wr(1'b0, 32'h0000_0008);
        chk("R6 irq on after enable", {31'b0, irq}, 32'h1);
        pulse_ev(3'b101);
        rd(1'b1, d); chk("R4 ioc and desc err", d, 32'h1C);
        wr(1'b1, 32'h0000_0008);
        rd(1'b1, d); chk("R5 w1c bit3 only", d, 32'h14);
        chk("R6 irq after clear", {31'b0, irq}, 32'h0);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, d); chk("R5 clear all", d, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        @(negedge clk);
        reg_sel = 1'b1; wr_en = 1'b1; wr_data = 32'h8; ev_fifo_err = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; ev_fifo_err = 1'b0;
        rd(1'b1, d); chk("R5 event beats clear", d, 32'h8);
        chk("R6 irq kept", {31'b0, irq}, 32'h1);
        wr(1'b1, 32'h8);
        wr(1'b0, 32'h0);
    endtask

    task automatic t_run;
        logic [31:0] d;
        dma_idle = 1'b0;
        ssync_hold = 1'b1;
        wr(1'b0, 32'h0000_0002);
        rd(1'b0, d); chk("R7 run reads 1", d & 32'h2, 32'h2);
        chk("R9 cad pulse", {31'b0, cad_rst}, 32'h1);
        chk("R7 hold blocks dma", {31'b0, dma_run}, 32'h0);
        @(negedge clk);
        chk("R9 cad one cycle", {31'b0, cad_rst}, 32'h0);
        ssync_hold = 1'b0; #1;
        chk("R7 dma runs", {31'b0, dma_run}, 32'h1);
        wr(1'b0, 32'h0000_0002);
        chk("R9 no pulse when already run", {31'b0, cad_rst}, 32'h0);
        wr(1'b0, 32'h0000_0001);
        chk("R8 dma stops", {31'b0, dma_run}, 32'h0);
        chk("R12 reset ignored while run reads 1", {31'b0, strm_rst}, 32'h0);
        repeat (3) @(negedge clk);
        rd(1'b0, d); chk("R8 run still 1", d & 32'h3, 32'h2);
        dma_idle = 1'b1;
        @(negedge clk);
        rd(1'b0, d); chk("R8 run reads 0 after idle", d & 32'h3, 32'h0);
        wr(1'b0, 32'h0000_0003);
        chk("R12 reset with run=1 ignored", {31'b0, strm_rst}, 32'h0);
        wr(1'b0, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_stream_reset;
        logic [31:0] d;
        wr(1'b0, 32'h0030_001C);
        pulse_ev(3'b111);
        rst_done = 1'b0; strm_ready = 1'b0;
        wr(1'b0, 32'h0030_001D);
        chk("R10 strm_rst raised", {31'b0, strm_rst}, 32'h1);
        repeat (2) @(negedge clk);
        rd(1'b0, d); chk("R10 srst reads 0 before done", d & 32'h1, 32'h0);
        rst_done = 1'b1;
        @(negedge clk);
        rst_done = 1'b0;
        rd(1'b0, d); chk("R10 in reset, fields cleared", d, 32'h0004_0001);
        rd(1'b1, d); chk("R10 status cleared", d, 32'h0);
        wr(1'b0, 32'h00A0_0017);
        rd(1'b0, d); chk("R13 writes ignored in reset", d, 32'h0004_0001);
        pulse_ev(3'b010);
        rd(1'b1, d); chk("R13 events ignored in reset", d, 32'h0);
        wr(1'b0, 32'h0);
        chk("R11 strm_rst dropped", {31'b0, strm_rst}, 32'h0);
        @(negedge clk);
        rd(1'b0, d); chk("R11 srst held until ready", d & 32'h1, 32'h1);
        strm_ready = 1'b1;
        @(negedge clk);
        strm_ready = 1'b0;
        rd(1'b0, d); chk("R11 srst reads 0", d, 32'h0004_0000);
        wr(1'b0, 32'h0090_0004);
        rd(1'b0, d); chk("R1 writable after exit", d, 32'h0094_0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_fields();
        t_status_irq();
        t_collide();
        t_run();
        t_stream_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule